// File: doc/BRIEF.md
# Reservation Station Bank with Result Bus Snooping

This block is a small bank of reservation stations that sits in front of one class of functional unit in an out-of-order core. An issue stage writes an operation into a station it names by index. For each of the two source operands it supplies either the value itself or a nonzero producer tag. Tag zero means the value is already present, so there is no separate ready flag. Each station has its own tag, equal to its index plus one. Tag zero is never used by a station.

While a station waits, it watches a shared result bus. The bus carries a valid bit, a 4-bit source tag and a 64-bit value. When the bus tag equals a missing operand's producer tag, the station copies the value in and clears that tag to zero. If an operand's producer broadcasts in the same cycle as the issue, the value is taken straight from the bus.

Once both tags are zero, the entry can be dispatched to the execution unit. When several entries are ready, the oldest is dispatched first, and only one entry is dispatched per cycle. A dispatched station stays busy until its own tag appears on the bus. At that point it reports the release and becomes free again.

Top module: `rsv_station_bank`

## Requirements
- R1: After reset every station is free (`st_free` all ones), `disp_valid` is 0 and `rel_valid` is 0.
- R2: An issue is accepted (`iss_accept` high in the same cycle) only when `iss_valid` is 1, `iss_idx` is below the station count, and that station is free. Any other issue is dropped and changes no station: the busy station keeps the operation and operands it already holds.
- R3: A source whose tag is 0 is taken as present. An entry whose two tags are both 0 after the issue edge appears on the dispatch port in the next cycle. An entry with a nonzero tag is never dispatched.
- R4: A waiting entry copies `bus_data` into an operand only when `bus_valid` is 1 and `bus_tag` equals that operand's nonzero tag, and that tag then becomes 0. Broadcasts with any other tag leave the entry waiting.
- R5: An issue whose source tag matches a valid broadcast in the same cycle takes the operand from the bus. The entry then behaves as if that operand had been supplied as a value.
- R6: When several entries are ready, the one issued earliest is dispatched first. At most one entry is dispatched per cycle, and each entry is dispatched exactly once.
- R7: The dispatch port shows the entry's operation, its two operand values, and `disp_tag` equal to the station index plus one.
- R8: A valid broadcast whose tag equals the tag of a dispatched station raises `rel_valid` in that cycle, with `rel_idx` set to the station index. The station is free from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_idx | input | 4 | Station index chosen by the issue stage |
| iss_op | input | 4 | Operation code |
| iss_vj | input | 64 | First operand value (used when `iss_qj` is 0) |
| iss_qj | input | 4 | First operand producer tag, 0 = present |
| iss_vk | input | 64 | Second operand value (used when `iss_qk` is 0) |
| iss_qk | input | 4 | Second operand producer tag, 0 = present |
| iss_accept | output | 1 | Issue taken this cycle |
| st_free | output | 4 | One bit per station, 1 = free |
| bus_valid | input | 1 | Result broadcast valid |
| bus_tag | input | 4 | Tag of the producing station |
| bus_data | input | 64 | Broadcast result value |
| disp_valid | output | 1 | An entry is dispatched this cycle |
| disp_op | output | 4 | Dispatched operation |
| disp_vj | output | 64 | Dispatched first operand |
| disp_vk | output | 64 | Dispatched second operand |
| disp_tag | output | 4 | Tag of the dispatched station |
| rel_valid | output | 1 | A station is released by this broadcast |
| rel_idx | output | 4 | Index of the released station |

## Verification
The hardest situation to reach is several entries becoming ready in the same cycle while they were issued in a different order from their station indices. Only then does the age ordering decide the dispatch order, rather than index priority. To reach it, the bench issues four entries in a chosen permutation of slots, all waiting on the same outside producer tag. It then releases them together with a single broadcast and checks that the dispatch tags follow the issue order. A sweep over every station and every present/waiting combination of the two operands covers snooping and release. A separate case drives the broadcast in the same cycle as the issue.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EXEC = 2'd2
  } rsv_state_e;

  // station tags start at 1: tag 0 means "operand present"
  function automatic int station_tag(input int idx);
    return idx + 1;
  endfunction

endpackage

// File: rtl/rsv_entry.sv
module rsv_entry
  import rsv_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4,
  parameter int MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [OP_W-1:0]   a_op,
  input  logic [DATA_W-1:0] a_vj,
  input  logic [TAG_W-1:0]  a_qj,
  input  logic [DATA_W-1:0] a_vk,
  input  logic [TAG_W-1:0]  a_qk,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              pick,
  output logic              busy,
  output logic              ready,
  output logic              release_o,
  output logic [OP_W-1:0]   e_op,
  output logic [DATA_W-1:0] e_vj,
  output logic [DATA_W-1:0] e_vk
);

  localparam logic [TAG_W-1:0] OWN_TAG = TAG_W'(MY_TAG);

  rsv_state_e       st;
  logic [TAG_W-1:0] qj, qk;

  function automatic logic snoop_hit(input logic v, input logic [TAG_W-1:0] btag,
                                     input logic [TAG_W-1:0] want);
    return v && (want != '0) && (btag == want);
  endfunction

  // named snoop events
  logic hit_j, hit_k, a_hit_j, a_hit_k;
  assign hit_j   = (st == ST_WAIT) && snoop_hit(bus_valid, bus_tag, qj);
  assign hit_k   = (st == ST_WAIT) && snoop_hit(bus_valid, bus_tag, qk);
  assign a_hit_j = alloc && snoop_hit(bus_valid, bus_tag, a_qj);
  assign a_hit_k = alloc && snoop_hit(bus_valid, bus_tag, a_qk);

  assign busy      = (st != ST_FREE);
  assign ready     = (st == ST_WAIT) && (qj == '0) && (qk == '0);
  assign release_o = (st == ST_EXEC) && bus_valid && (bus_tag == OWN_TAG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_FREE;
      qj   <= '0;
      qk   <= '0;
      e_op <= '0;
      e_vj <= '0;
      e_vk <= '0;
    end else begin
      case (st)
        ST_FREE: begin
          if (alloc) begin
            st   <= ST_WAIT;
            e_op <= a_op;
            e_vj <= a_hit_j ? bus_data : a_vj;
            qj   <= a_hit_j ? '0 : a_qj;
            e_vk <= a_hit_k ? bus_data : a_vk;
            qk   <= a_hit_k ? '0 : a_qk;
          end
        end
        ST_WAIT: begin
          if (hit_j) begin
            e_vj <= bus_data;
            qj   <= '0;
          end
          if (hit_k) begin
            e_vk <= bus_data;
            qk   <= '0;
          end
          if (pick) st <= ST_EXEC;
        end
        ST_EXEC: begin
          if (release_o) st <= ST_FREE;
        end
        default: st <= ST_FREE;
      endcase
    end
  end

  assert_alloc_only_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> (st == ST_FREE));

  assert_pick_only_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pick |-> (st == ST_WAIT && qj == '0 && qk == '0));

  assert_snoop_capture_j_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_j |=> (qj == '0 && e_vj == $past(bus_data)));

  assert_snoop_capture_k_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_k |=> (qk == '0 && e_vk == $past(bus_data)));

  assert_issue_bus_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    a_hit_j |=> (qj == '0 && e_vj == $past(bus_data)));

  assert_pick_leaves_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pick |=> (st == ST_EXEC));

  assert_release_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |=> (st == ST_FREE));

endmodule

// File: rtl/rsv_age_pick.sv
module rsv_age_pick #(
  parameter int NUM_ST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_ST-1:0] alloc,
  input  logic [NUM_ST-1:0] busy,
  input  logic [NUM_ST-1:0] ready,
  output logic [NUM_ST-1:0] grant
);

  // older[j][i] = 1 : entry j was issued before entry i
  logic [NUM_ST-1:0] older [NUM_ST];
  logic [NUM_ST-1:0] blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_ST; r++) older[r] <= '0;
    end else begin
      for (int s = 0; s < NUM_ST; s++) begin
        if (alloc[s]) begin
          for (int j = 0; j < NUM_ST; j++) begin
            older[s][j] <= 1'b0;
            if (j != s) older[j][s] <= busy[j];
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_ST; i++) begin
      blocked[i] = 1'b0;
      for (int j = 0; j < NUM_ST; j++)
        if (ready[j] && older[j][i]) blocked[i] = 1'b1;
      grant[i] = ready[i] && !blocked[i];
    end
  end

  assert_single_dispatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_work_conserving_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|ready) |-> (|grant));

  assert_grant_is_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~ready) == '0);

  assert_single_alloc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc));

endmodule

// File: rtl/rsv_station_bank.sv
module rsv_station_bank
  import rsv_pkg::*;
#(
  parameter int NUM_ST = 4,
  parameter int OP_W   = 4,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [TAG_W-1:0]  iss_idx,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [DATA_W-1:0] iss_vj,
  input  logic [TAG_W-1:0]  iss_qj,
  input  logic [DATA_W-1:0] iss_vk,
  input  logic [TAG_W-1:0]  iss_qk,
  output logic              iss_accept,
  output logic [NUM_ST-1:0] st_free,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  output logic              disp_valid,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_vj,
  output logic [DATA_W-1:0] disp_vk,
  output logic [TAG_W-1:0]  disp_tag,
  output logic              rel_valid,
  output logic [TAG_W-1:0]  rel_idx
);

  logic [NUM_ST-1:0] alloc_vec, busy_vec, ready_vec, grant_vec, rel_vec;
  logic [OP_W-1:0]   op_arr [NUM_ST];
  logic [DATA_W-1:0] vj_arr [NUM_ST];
  logic [DATA_W-1:0] vk_arr [NUM_ST];

  for (genvar g = 0; g < NUM_ST; g++) begin : g_st
    assign alloc_vec[g] = iss_valid && (iss_idx == TAG_W'(g)) && !busy_vec[g];

    rsv_entry #(
      .OP_W  (OP_W),
      .DATA_W(DATA_W),
      .TAG_W (TAG_W),
      .MY_TAG(station_tag(g))
    ) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc    (alloc_vec[g]),
      .a_op     (iss_op),
      .a_vj     (iss_vj),
      .a_qj     (iss_qj),
      .a_vk     (iss_vk),
      .a_qk     (iss_qk),
      .bus_valid(bus_valid),
      .bus_tag  (bus_tag),
      .bus_data (bus_data),
      .pick     (grant_vec[g]),
      .busy     (busy_vec[g]),
      .ready    (ready_vec[g]),
      .release_o(rel_vec[g]),
      .e_op     (op_arr[g]),
      .e_vj     (vj_arr[g]),
      .e_vk     (vk_arr[g])
    );
  end

  rsv_age_pick #(.NUM_ST(NUM_ST)) u_pick (
    .clk  (clk),
    .rst_n(rst_n),
    .alloc(alloc_vec),
    .busy (busy_vec),
    .ready(ready_vec),
    .grant(grant_vec)
  );

  assign iss_accept = |alloc_vec;
  assign st_free    = ~busy_vec;
  assign disp_valid = |grant_vec;
  assign rel_valid  = |rel_vec;

  always_comb begin
    disp_op  = '0;
    disp_vj  = '0;
    disp_vk  = '0;
    disp_tag = '0;
    rel_idx  = '0;
    for (int i = 0; i < NUM_ST; i++) begin
      if (grant_vec[i]) begin
        disp_op  = op_arr[i];
        disp_vj  = vj_arr[i];
        disp_vk  = vk_arr[i];
        disp_tag = TAG_W'(station_tag(i));
      end
      if (rel_vec[i]) rel_idx = TAG_W'(i);
    end
  end

  assert_issue_takes_station_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_accept && !rel_valid) |=> ($countones(st_free) == $past($countones(st_free)) - 1));

  assert_release_returns_station_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !iss_accept) |=> ($countones(st_free) == $past($countones(st_free)) + 1));

  assert_no_dispatch_tag_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (disp_tag != '0));

endmodule

// File: tb/rsv_station_bank_bench.sv
module rsv_station_bank_bench;

  localparam int N  = 4;
  localparam int OW = 4;
  localparam int DW = 64;
  localparam int TW = 4;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          iss_valid = 0;
  logic [TW-1:0] iss_idx = '0;
  logic [OW-1:0] iss_op = '0;
  logic [DW-1:0] iss_vj = '0, iss_vk = '0;
  logic [TW-1:0] iss_qj = '0, iss_qk = '0;
  logic          iss_accept;
  logic [N-1:0]  st_free;
  logic          bus_valid = 0;
  logic [TW-1:0] bus_tag = '0;
  logic [DW-1:0] bus_data = '0;
  logic          disp_valid;
  logic [OW-1:0] disp_op;
  logic [DW-1:0] disp_vj, disp_vk;
  logic [TW-1:0] disp_tag;
  logic          rel_valid;
  logic [TW-1:0] rel_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rsv_station_bank #(.NUM_ST(N), .OP_W(OW), .DATA_W(DW), .TAG_W(TW)) u_rsv_station_bank (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_idx(iss_idx), .iss_op(iss_op),
    .iss_vj(iss_vj), .iss_qj(iss_qj), .iss_vk(iss_vk), .iss_qk(iss_qk),
    .iss_accept(iss_accept), .st_free(st_free),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
    .disp_valid(disp_valid), .disp_op(disp_op), .disp_vj(disp_vj), .disp_vk(disp_vk),
    .disp_tag(disp_tag), .rel_valid(rel_valid), .rel_idx(rel_idx)
  );

  task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // advance to just after the next rising edge and return all inputs to idle
  task automatic cyc();
    @(posedge clk);
    #1;
    iss_valid = 0; iss_idx = '0; iss_op = '0;
    iss_vj = '0; iss_vk = '0; iss_qj = '0; iss_qk = '0;
    bus_valid = 0; bus_tag = '0; bus_data = '0;
  endtask

  task automatic settle();
    #4;
  endtask

  task automatic drive_issue(input int idx, input int op, input logic [DW-1:0] vj, input int qj,
                             input logic [DW-1:0] vk, input int qk);
    iss_valid = 1; iss_idx = TW'(idx); iss_op = OW'(op);
    iss_vj = vj; iss_qj = TW'(qj); iss_vk = vk; iss_qk = TW'(qk);
  endtask

  task automatic drive_bus(input int tag, input logic [DW-1:0] d);
    bus_valid = 1; bus_tag = TW'(tag); bus_data = d;
  endtask

  function automatic logic [DW-1:0] val_of(input int s, input int m, input int which);
    return 64'h0F1E_2D3C_0000_0000 ^ DW'(s * 977 + m * 131 + which * 7919);
  endfunction

  // release station s (tag s+1) and confirm
  task automatic release_station(input int s);
    cyc();
    drive_bus(s + 1, '0);
    settle();
    chk("R8 rel_valid", DW'(rel_valid), 1);
    chk("R8 rel_idx", DW'(rel_idx), DW'(s));
  endtask

  task automatic age_run(input int o0, input int o1, input int o2, input int o3);
    int ord [4];
    ord[0] = o0; ord[1] = o1; ord[2] = o2; ord[3] = o3;
    for (int n = 0; n < 4; n++) begin
      cyc();
      drive_issue(ord[n], n, 0, 9, 64'h55 + DW'(n), 0);
    end
    cyc();
    settle();
    chk("R3 waiting entries not dispatched", DW'(disp_valid), 0);
    drive_bus(9, 64'hCAFE_0000_0000_0009);
    for (int n = 0; n < 4; n++) begin
      cyc();
      settle();
      chk("R6 dispatch valid in age order", DW'(disp_valid), 1);
      chk("R6 oldest dispatched first", DW'(disp_tag), DW'(ord[n] + 1));
      chk("R6 op follows entry", DW'(disp_op), DW'(n));
      chk("R4 shared capture", disp_vj, 64'hCAFE_0000_0000_0009);
    end
    cyc();
    settle();
    chk("R6 each entry dispatched once", DW'(disp_valid), 0);
    for (int n = 0; n < 4; n++) release_station(ord[n]);
    cyc();
    settle();
    chk("R8 all free after releases", DW'(st_free), DW'(4'hF));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    settle();
    chk("R1 reset free", DW'(st_free), DW'(4'hF));
    chk("R1 reset no dispatch", DW'(disp_valid), 0);
    chk("R1 reset no release", DW'(rel_valid), 0);
    @(posedge clk);
    #1;
    rst_n = 1;

    // sweep every station and every present/waiting mix of the two operands
    for (int s = 0; s < N; s++) begin
      for (int m = 0; m < 4; m++) begin
        bit jw, kw;
        logic [DW-1:0] ej, ek;
        jw = m[0]; kw = m[1];
        ej = val_of(s, m, 0);
        ek = val_of(s, m, 1);
        cyc();
        drive_issue(s, s * 4 + m, jw ? 64'hDEAD : ej, jw ? 9 : 0, kw ? 64'hBEEF : ek, kw ? 10 : 0);
        settle();
        chk("R2 accept free station", DW'(iss_accept), 1);
        if (jw || kw) begin
          cyc();
          settle();
          chk("R3 nonzero tag blocks dispatch", DW'(disp_valid), 0);
          drive_bus(11, 64'h1111);
          cyc();
          settle();
          chk("R4 other tag ignored", DW'(disp_valid), 0);
          if (jw) drive_bus(9, ej);
          if (jw && kw) begin
            cyc();
            settle();
            chk("R4 still waiting on second", DW'(disp_valid), 0);
          end
          if (kw) drive_bus(10, ek);
        end
        cyc();
        settle();
        chk("R3 ready entry dispatched", DW'(disp_valid), 1);
        chk("R7 disp_tag", DW'(disp_tag), DW'(s + 1));
        chk("R7 disp_op", DW'(disp_op), DW'((s * 4 + m) % 16));
        chk("R7 disp_vj", disp_vj, ej);
        chk("R7 disp_vk", disp_vk, ek);
        release_station(s);
        chk("R6 no second dispatch", DW'(disp_valid), 0);
        cyc();
        settle();
        chk("R8 station free again", DW'(st_free), DW'(4'hF));
      end
    end

    // stall: busy station and out-of-range index
    cyc();
    drive_issue(1, 3, 0, 9, 64'h77, 0);
    cyc();
    settle();
    chk("R2 busy bit", DW'(st_free), DW'(4'b1101));
    drive_issue(1, 5, 64'h1, 0, 64'h2, 0);
    settle();
    chk("R2 busy station refuses", DW'(iss_accept), 0);
    cyc();
    drive_issue(5, 5, 64'h1, 0, 64'h2, 0);
    settle();
    chk("R2 index out of range refused", DW'(iss_accept), 0);
    cyc();
    iss_idx = 4'd0;
    settle();
    chk("R2 no valid no accept", DW'(iss_accept), 0);
    cyc();
    settle();
    chk("R2 refused issues left no trace", DW'(st_free), DW'(4'b1101));
    chk("R2 no dispatch from refused issue", DW'(disp_valid), 0);
    drive_bus(9, 64'h99);
    cyc();
    settle();
    chk("R2 original op kept", DW'(disp_op), 3);
    chk("R2 original vk kept", disp_vk, 64'h77);
    chk("R4 vj captured", disp_vj, 64'h99);
    release_station(1);

    // same-cycle issue and broadcast
    cyc();
    drive_issue(3, 6, 64'hBAD, 12, 64'h44, 0);
    drive_bus(12, 64'h1234_5678_9ABC_DEF0);
    cyc();
    settle();
    chk("R5 dispatch after bus capture at issue", DW'(disp_valid), 1);
    chk("R5 captured value", disp_vj, 64'h1234_5678_9ABC_DEF0);
    chk("R5 tag", DW'(disp_tag), 4);
    release_station(3);

    // age ordering across permutations
    age_run(2, 0, 3, 1);
    age_run(3, 2, 1, 0);
    age_run(1, 3, 0, 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule